// File: doc/BRIEF.md
# Dual-Channel Seven-to-One Serial Lane Formatter

This block takes one odd pixel and one even pixel per pixel period. Each pixel has 8-bit red, green and blue values, and a shared data-enable flag comes with them. Per channel, the block packs these into four 7-bit data-lane words. It then shifts every word out one bit per cycle of a bit clock that runs seven times the pixel rate. Each channel also gets a forwarded-clock lane that repeats a fixed seven-slot pattern, aligned to the word boundary. The two channels share one slot counter, so all ten serial outputs change words on the same bit-clock edge.

The block runs entirely in the bit-clock domain. A slot counter counts bit periods 0 to 6. The pixel inputs are sampled only on the edge that ends slot 6. That edge loads the new words, and it is also the first edge after reset is released. Upstream logic must hold the pixel inputs valid across that edge. The differential drivers, the multiplying PLL and the raster timing generator are outside this block.

Top module: `lvds_pair_formatter`

## Requirements
- R1: While rst_ni is low, every data-lane and clock-lane output is 0.
- R2: Each forwarded-clock output shows the pattern 1,1,0,0,0,1,1 in slots 0 to 6 of every word, so it is high for four of seven bit periods. Slot 0 is the first bit period after a load edge.
- R3: Data lane 0 carries red bits 0..5 in word positions 0..5 and green bit 0 in position 6.
- R4: Data lane 1 carries green bits 1..5 in positions 0..4, blue bit 0 in position 5 and blue bit 1 in position 6.
- R5: Data lane 2 carries blue bits 2..5 in positions 0..3, 0 in positions 4 and 5, and the data-enable flag in position 6.
- R6: Data lane 3 carries red bits 6,7 in positions 0,1, green bits 6,7 in positions 2,3, blue bits 6,7 in positions 4,5, and 0 in position 6.
- R7: The word is sent highest position first: in slot s the lane output equals word position 6-s. A new word is loaded every seven bit clocks, on the same edge for all lanes.
- R8: The even channel uses the same lane mapping as the odd channel, applied to its own colour inputs. Its clock-lane output is identical to the odd channel's on every cycle.
- R9: When the data-enable flag is low at a load edge, every data lane of both channels sends all-zero words, whatever the colour inputs.
- R10: Colour and data-enable inputs are sampled only at the load edge. Changes to them in other slots do not affect the word being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk_i | input | 1 | Bit clock, seven times the pixel rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| de_i | input | 1 | Data-enable flag shared by both pixels |
| odd_red_i | input | 8 | Odd pixel red |
| odd_grn_i | input | 8 | Odd pixel green |
| odd_blu_i | input | 8 | Odd pixel blue |
| evn_red_i | input | 8 | Even pixel red |
| evn_grn_i | input | 8 | Even pixel green |
| evn_blu_i | input | 8 | Even pixel blue |
| odd_lane_o | output | 4 | Odd channel serial data lanes, bit n is lane n |
| odd_fclk_o | output | 1 | Odd channel forwarded-clock lane |
| evn_lane_o | output | 4 | Even channel serial data lanes, bit n is lane n |
| evn_fclk_o | output | 1 | Even channel forwarded-clock lane |

## Verification
Some properties are checked by assertions on every cycle. The slot counter must advance by one and wrap every seven cycles. Both clock lanes must match each other and follow the fixed pattern for their slot. The spare positions in lanes 2 and 3 must go out as 0. A word loaded with data-enable low must start with zero bits. The assertions cannot prove that each colour bit reaches its correct lane and slot, or that an input change between load edges is ignored. Only the bench shows these, by sweeping a walking one through every colour bit of the odd pixel and running many mixed patterns, blanked pixels and mid-word input changes.

// File: rtl/lvds_fmt_pkg.sv
package lvds_fmt_pkg;
    localparam int COLOR_W    = 8;
    localparam int SLOTS      = 7;
    localparam int DATA_LANES = 4;
    localparam int CHANNELS   = 2;
    // Forwarded-clock word, sent highest bit first: slots 0..6 = 1100011
    localparam logic [SLOTS-1:0] CLK_PATTERN = 7'b1100011;
endpackage

// File: rtl/slot_sequencer.sv
module slot_sequencer #(
    parameter int SLOTS = lvds_fmt_pkg::SLOTS
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    output logic                       load_o,
    output logic [$clog2(SLOTS)-1:0]   slot_o
);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.slot == LAST) begin
            st_d.slot = '0;
        end else begin
            st_d.slot = st_q.slot + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{slot: LAST};
        end else begin
            st_q <= st_d;
        end
    end

    assign load_o = (st_q.slot == LAST);
    assign slot_o = st_q.slot;

    AST_SLOT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && st_q.slot != '0) |-> (st_q.slot == $past(st_q.slot) + 1'b1)); // R7
    AST_SLOT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.slot <= LAST)); // R7
endmodule

// File: rtl/pixel_lane_mapper.sv
module pixel_lane_mapper #(
    parameter int COLOR_W    = lvds_fmt_pkg::COLOR_W,
    parameter int SLOTS      = lvds_fmt_pkg::SLOTS,
    parameter int DATA_LANES = lvds_fmt_pkg::DATA_LANES
) (
    input  logic [COLOR_W-1:0]                  red_i,
    input  logic [COLOR_W-1:0]                  grn_i,
    input  logic [COLOR_W-1:0]                  blu_i,
    input  logic                                de_i,
    output logic [DATA_LANES-1:0][SLOTS-1:0]    word_o
);
    // Six low colour bits per primary go to lanes 0..2; the two top bits to lane 3
    localparam int LOW_W = COLOR_W - 2;
    localparam int TOP   = SLOTS - 1;

    logic [COLOR_W-1:0] red_v, grn_v, blu_v;

    always_comb begin
        red_v = de_i ? red_i : '0;
        grn_v = de_i ? grn_i : '0;
        blu_v = de_i ? blu_i : '0;

        word_o = '0;
        // lane 0: red low six, green bit 0 on top
        word_o[0][LOW_W-1:0]   = red_v[LOW_W-1:0];
        word_o[0][TOP]         = grn_v[0];
        // lane 1: green 1..5, blue 0 and 1 on top
        word_o[1][LOW_W-2:0]   = grn_v[LOW_W-1:1];
        word_o[1][TOP-1]       = blu_v[0];
        word_o[1][TOP]         = blu_v[1];
        // lane 2: blue 2..5, two spare zeros, enable flag on top
        word_o[2][LOW_W-3:0]   = blu_v[LOW_W-1:2];
        word_o[2][TOP]         = de_i;
        // lane 3: top pairs of red, green, blue; top position spare
        word_o[3][1:0]         = red_v[COLOR_W-1:LOW_W];
        word_o[3][3:2]         = grn_v[COLOR_W-1:LOW_W];
        word_o[3][5:4]         = blu_v[COLOR_W-1:LOW_W];
    end
endmodule

// File: rtl/lane_serializer.sv
module lane_serializer #(
    parameter int LANES = lvds_fmt_pkg::DATA_LANES + 1,
    parameter int SLOTS = lvds_fmt_pkg::SLOTS
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          load_i,
    input  logic [LANES-1:0][SLOTS-1:0]   word_i,
    output logic [LANES-1:0]              bit_o
);
    typedef struct packed {
        logic [LANES-1:0][SLOTS-1:0] sh;
    } ser_t;

    ser_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.sh = word_i;
        end else begin
            for (int l = 0; l < LANES; l++) begin
                st_d.sh[l] = {st_q.sh[l][SLOTS-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_out
        assign bit_o[l] = st_q.sh[l][SLOTS-1];
    end
endmodule

// File: rtl/lvds_pair_formatter.sv
module lvds_pair_formatter #(
    parameter int COLOR_W    = lvds_fmt_pkg::COLOR_W,
    parameter int SLOTS      = lvds_fmt_pkg::SLOTS,
    parameter int DATA_LANES = lvds_fmt_pkg::DATA_LANES,
    parameter int CHANNELS   = lvds_fmt_pkg::CHANNELS
) (
    input  logic                   bit_clk_i,
    input  logic                   rst_ni,
    input  logic                   de_i,
    input  logic [COLOR_W-1:0]     odd_red_i,
    input  logic [COLOR_W-1:0]     odd_grn_i,
    input  logic [COLOR_W-1:0]     odd_blu_i,
    input  logic [COLOR_W-1:0]     evn_red_i,
    input  logic [COLOR_W-1:0]     evn_grn_i,
    input  logic [COLOR_W-1:0]     evn_blu_i,
    output logic [DATA_LANES-1:0]  odd_lane_o,
    output logic                   odd_fclk_o,
    output logic [DATA_LANES-1:0]  evn_lane_o,
    output logic                   evn_fclk_o
);
    localparam int SLOT_W    = $clog2(SLOTS);
    localparam int ALL_LANES = DATA_LANES + 1;
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

    logic                                            load_w;
    logic [SLOT_W-1:0]                               slot_w;
    logic [COLOR_W-1:0]                              red_a [CHANNELS];
    logic [COLOR_W-1:0]                              grn_a [CHANNELS];
    logic [COLOR_W-1:0]                              blu_a [CHANNELS];
    logic [CHANNELS-1:0][DATA_LANES-1:0][SLOTS-1:0]  data_w;
    logic [CHANNELS-1:0][ALL_LANES-1:0][SLOTS-1:0]   full_w;
    logic [CHANNELS-1:0][ALL_LANES-1:0]              ser_bits;

    assign red_a[0] = odd_red_i;
    assign grn_a[0] = odd_grn_i;
    assign blu_a[0] = odd_blu_i;
    assign red_a[1] = evn_red_i;
    assign grn_a[1] = evn_grn_i;
    assign blu_a[1] = evn_blu_i;

    slot_sequencer #(.SLOTS(SLOTS)) seq_i (
        .clk_i  (bit_clk_i),
        .rst_ni (rst_ni),
        .load_o (load_w),
        .slot_o (slot_w)
    );

    for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
        pixel_lane_mapper #(
            .COLOR_W    (COLOR_W),
            .SLOTS      (SLOTS),
            .DATA_LANES (DATA_LANES)
        ) map_i (
            .red_i  (red_a[ch]),
            .grn_i  (grn_a[ch]),
            .blu_i  (blu_a[ch]),
            .de_i   (de_i),
            .word_o (data_w[ch])
        );

        // clock lane rides as the extra top lane of each channel's shifter
        assign full_w[ch] = {lvds_fmt_pkg::CLK_PATTERN, data_w[ch]};

        lane_serializer #(
            .LANES (ALL_LANES),
            .SLOTS (SLOTS)
        ) ser_i (
            .clk_i  (bit_clk_i),
            .rst_ni (rst_ni),
            .load_i (load_w),
            .word_i (full_w[ch]),
            .bit_o  (ser_bits[ch])
        );
    end

    assign odd_lane_o = ser_bits[0][DATA_LANES-1:0];
    assign odd_fclk_o = ser_bits[0][DATA_LANES];
    assign evn_lane_o = ser_bits[1][DATA_LANES-1:0];
    assign evn_fclk_o = ser_bits[1][DATA_LANES];

    AST_RESET_QUIET: assert property (@(posedge bit_clk_i)
        (!rst_ni) |-> (odd_lane_o == '0 && evn_lane_o == '0 && !odd_fclk_o && !evn_fclk_o)); // R1
    AST_FCLK_SLOT: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> (odd_fclk_o == lvds_fmt_pkg::CLK_PATTERN[LAST - slot_w])); // R2
    AST_FCLK_PAIR: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
        (odd_fclk_o == evn_fclk_o)); // R8
    AST_LANE2_SPARE: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
        (slot_w == SLOT_W'(1) || slot_w == SLOT_W'(2)) |-> (!odd_lane_o[2] && !evn_lane_o[2])); // R5
    AST_LANE3_SPARE: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && slot_w == '0) |-> (!odd_lane_o[3] && !evn_lane_o[3])); // R6
    AST_BLANK_WORD: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
        (load_w && !de_i) |=> (odd_lane_o == '0 && evn_lane_o == '0)); // R9
endmodule

// File: tb/lvds_pair_formatter_tb.sv
module lvds_pair_formatter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       de = 1'b0;
    logic [7:0] o_r = '0, o_g = '0, o_b = '0;
    logic [7:0] e_r = '0, e_g = '0, e_b = '0;
    logic [3:0] odd_lane, evn_lane;
    logic       odd_fclk, evn_fclk;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    localparam logic [6:0] FCLK_EXP = 7'b1100011;

    always #5 clk = ~clk;

    lvds_pair_formatter dut_i (
        .bit_clk_i  (clk),
        .rst_ni     (rst_n),
        .de_i       (de),
        .odd_red_i  (o_r),
        .odd_grn_i  (o_g),
        .odd_blu_i  (o_b),
        .evn_red_i  (e_r),
        .evn_grn_i  (e_g),
        .evn_blu_i  (e_b),
        .odd_lane_o (odd_lane),
        .odd_fclk_o (odd_fclk),
        .evn_lane_o (evn_lane),
        .evn_fclk_o (evn_fclk)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Expected bit of lane l at word position p, from the requirement tables
    function automatic logic exp_bit(input int l, input int p, input logic [7:0] r,
                                     input logic [7:0] g, input logic [7:0] b, input logic en);
        logic [5:0] tops;
        tops = {b[7:6], g[7:6], r[7:6]};
        if (l == 2 && p == 6) return en;
        if (!en) return 1'b0;
        case (l)
            0: return (p < 6) ? r[p] : g[0];
            1: return (p < 5) ? g[p+1] : b[p-5];
            2: return (p < 4) ? b[p+2] : 1'b0;
            default: return (p < 6) ? tops[p] : 1'b0;
        endcase
    endfunction

    function automatic string lane_tag(input int l);
        case (l)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    // Called at a negedge just before a load edge; returns at the next such point
    task automatic run_pixel(input logic [7:0] ar, ag, ab, br, bg, bb,
                             input logic en, input bit glitch, input string extra);
        o_r = ar; o_g = ag; o_b = ab;
        e_r = br; e_g = bg; e_b = bb;
        de  = en;
        for (int s = 0; s < 7; s++) begin
            @(posedge clk);
            @(negedge clk);
            for (int l = 0; l < 4; l++) begin
                chk($sformatf("%s R7 %s odd lane%0d slot%0d", lane_tag(l), extra, l, s),
                    odd_lane[l], exp_bit(l, 6 - s, ar, ag, ab, en));
                chk($sformatf("%s R8 R7 %s even lane%0d slot%0d", lane_tag(l), extra, l, s),
                    evn_lane[l], exp_bit(l, 6 - s, br, bg, bb, en));
            end
            chk($sformatf("R2 R8 clock lanes slot%0d", s), {odd_fclk, evn_fclk},
                {2{FCLK_EXP[6 - s]}});
            if (glitch && s == 3) begin
                o_r = ~ar; o_g = ~ag; o_b = ~ab;
                e_r = ~br; e_g = ~bg; e_b = ~bb;
                de  = ~en;
            end
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        o_r = 8'hFF; e_b = 8'hFF; de = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 reset odd lanes", odd_lane, 4'h0);
        chk("R1 reset even lanes", evn_lane, 4'h0);
        chk("R1 reset clock lanes", {odd_fclk, evn_fclk}, 2'b00);
        rst_n = 1'b1;

        // walking one through every odd colour bit, even pixel holds the complement
        for (int i = 0; i < 24; i++) begin
            logic [23:0] v;
            v = 24'h1 << i;
            run_pixel(v[7:0], v[15:8], v[23:16], ~v[7:0], ~v[15:8], ~v[23:16],
                      1'b1, 1'b0, "walk");
        end
        // mixed arithmetic patterns
        for (int i = 0; i < 24; i++) begin
            run_pixel(8'(i * 37 + 11), 8'(i * 91 + 5), 8'(i * 53 + 200),
                      8'(i * 29 + 77), 8'(255 - i * 13), 8'(i * 71),
                      1'b1, 1'b0, "mix");
        end
        run_pixel(8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b0, "full");
        // blanking with busy colours
        for (int i = 0; i < 3; i++) begin
            run_pixel(8'hFF, 8'(8'hA5 + i), 8'h5A, 8'hC3, 8'h3C, 8'(8'hF0 - i),
                      1'b0, 1'b0, "R9 blank");
        end
        // input changes in mid-word must not show
        for (int i = 0; i < 3; i++) begin
            run_pixel(8'(8'h12 + i), 8'h34, 8'h56, 8'h78, 8'h9A, 8'(8'hBC + i),
                      1'b1, 1'b1, "R10 midword");
        end
        run_pixel(8'h0F, 8'hF0, 8'h81, 8'h7E, 8'h18, 8'hE7, 1'b0, 1'b1, "R10 R9 midword");
        run_pixel(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, "zero");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule